// File: doc/BRIEF.md
# Mode-Controlled Serial Shift Register

This block is an 8-bit shift register that a processor loads and reads over a simple parallel port. It also has two serial pins: a shift clock and a serial data line. A 3-bit mode input chooses what the register does. In the off mode the register only holds data. In the timed receive mode the block drives its own shift clock and clocks in eight bits from the data pin. In the free-running transmit mode it rotates its contents out on the data pin without stopping.

A shift sequence starts whenever the processor reads or writes the register. In both shifting modes the block generates the shift clock itself. Each clock phase lasts a number of cycles set by a timer reload byte. In receive mode the block raises a completion flag after eight rising clock edges and then parks the clock high. The flag clears on the next access.

Top module: `ser_shift_unit`

## Requirements
- R1: With mode 000 (and any mode other than 001 or 100) there is no shifting. The register is still written by `cpu_wr`, `sclk_out` stays high, `sclk_oe` and `sdat_oe` are 0 from the cycle after the mode is applied, and `done_flag` is never set.
- R2: In modes 001 and 100, after an access with `tmr_lo` = N, `sclk_out` first falls N+2 cycles after the access edge. After that it toggles every N+2 cycles.
- R3: In mode 001, at each rising edge of `sclk_out` the register shifts one place toward bit 7 and takes `sdat_in` into bit 0. The first bit received therefore ends up in bit 7.
- R4: In mode 001, `done_flag` is set at the 8th rising edge of `sclk_out`. The clock then stays high and does not toggle again until the next access.
- R5: Any access (read or write) clears `done_flag`, forces `sclk_out` high and restarts the bit count and the phase timing. The flag is then due 8 full rising edges after the latest access.
- R6: In mode 100, `sdat_oe` is 1 and `sdat_out` is bit 7 of the register. At each falling edge of `sclk_out` the register rotates one place toward bit 7, with bit 7 moving into bit 0. The clock runs without stopping, and `done_flag` stays 0.
- R7: `cpu_rdata` is a registered copy of the register, one cycle behind it. A `cpu_rd` pulse starts a shift sequence just as a write does.
- R8: Leaving modes 001/100 while shifting stops the clock high within one cycle and removes both output enables.
- R9: After reset, `sclk_out` is 1 and `done_flag`, `sclk_oe`, `sdat_oe` and `cpu_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | 000 off, 001 timed receive, 100 free-running rotate-out |
| cpu_wr | input | 1 | Write strobe; loads `cpu_wdata` and starts shifting |
| cpu_rd | input | 1 | Read strobe; starts shifting |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered register contents |
| tmr_lo | input | 8 | Clock phase reload value N |
| sdat_in | input | 1 | Serial data in |
| sclk_out | output | 1 | Generated shift clock, idles high |
| sclk_oe | output | 1 | Drive enable for the shift clock pin |
| sdat_out | output | 1 | Serial data out (bit 7) |
| sdat_oe | output | 1 | Drive enable for the data pin |
| done_flag | output | 1 | Eight bits received |

## Verification
Each clock edge comes N+2 cycles after the previous one, and the first falling edge comes N+2 cycles after the access edge. The bench therefore counts whole cycles, sampling at the falling edge of `clk` after each access, and compares the count with N+2 exactly. The flag and the shifted data are due at the same edge as the 8th rising shift clock, and `cpu_rdata` follows one cycle later. For these results the bench waits for the observed shift clock level and then allows two cycles before comparing. Stop and ignore cases are checked by counting `sclk_out` transitions over a fixed window, where zero transitions is the expected result.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam logic [2:0] MODE_OFF      = 3'b000;
  localparam logic [2:0] MODE_IN_TMR   = 3'b001;
  localparam logic [2:0] MODE_OUT_FREE = 3'b100;

  function automatic logic is_shift_mode(input logic [2:0] m);
    return (m == MODE_IN_TMR) || (m == MODE_OUT_FREE);
  endfunction
endpackage

// File: rtl/ssu_rate_gen.sv
module ssu_rate_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] half,
  output logic             sclk,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int W = CNT_W + 1;

  logic [W-1:0] cnt;
  logic [W-1:0] reload;
  logic         tick;

  assign reload = W'(half) + W'(1);
  assign tick   = run && !restart && (cnt == '0);
  assign rise_o = tick && !sclk;
  assign fall_o = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (restart || !run) begin
      cnt  <= reload;
      sclk <= 1'b1;
    end else if (cnt == '0) begin
      cnt  <= reload;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt - W'(1);
    end
  end

  // R2: the clock holds its level while the phase counter is still nonzero
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && cnt != '0) |=> $stable(sclk));
  // R8: with no run request the clock parks high
  a_r8_park_high: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> sclk);
endmodule

// File: rtl/ssu_bit_ctr.sv
module ssu_bit_ctr #(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic last,
  output logic flag
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [CW-1:0] cnt;

  assign last = step && (cnt == CW'(DW - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (step) begin
      if (cnt == CW'(DW - 1)) begin
        cnt  <= '0;
        flag <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R5: an access always leaves the flag low
  a_r5_clear_drops_flag: assert property (@(posedge clk) disable iff (rst)
    clr |=> !flag);
  // R4: the flag only rises on a counted clock edge
  a_r4_flag_on_step: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(step));
endmodule

// File: rtl/ssu_shreg.sv
module ssu_shreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  input  logic          shift_in,
  input  logic          din,
  input  logic          rotate,
  output logic [DW-1:0] sr
);
  always_ff @(posedge clk) begin
    if (rst)
      sr <= '0;
    else if (load)
      sr <= wdata;
    else if (shift_in)
      sr <= {sr[DW-2:0], din};
    else if (rotate)
      sr <= {sr[DW-2:0], sr[DW-1]};
  end

  // R6: rotation never gains or loses a one
  a_r6_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
    (rotate && !load && !shift_in) |=> ($countones(sr) == $countones($past(sr))));
  // R3: received bit lands in bit 0
  a_r3_bit0_takes_din: assert property (@(posedge clk) disable iff (rst)
    (shift_in && !load) |=> (sr[0] == $past(din)));
endmodule

// File: rtl/ser_shift_unit.sv
module ser_shift_unit #(
  parameter int DW    = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  input  logic [CNT_W-1:0] tmr_lo,
  input  logic             sdat_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             sdat_out,
  output logic             sdat_oe,
  output logic             done_flag
);
  import ssu_pkg::*;

  logic          access, shifting, in_mode, out_mode;
  logic          active, run;
  logic          rise, fall, last;
  logic [DW-1:0] sr;

  assign access   = cpu_wr || cpu_rd;
  assign shifting = is_shift_mode(mode);
  assign in_mode  = (mode == MODE_IN_TMR);
  assign out_mode = (mode == MODE_OUT_FREE);
  assign run      = active && shifting;

  always_ff @(posedge clk) begin
    if (rst)
      active <= 1'b0;
    else if (!shifting)
      active <= 1'b0;
    else if (access)
      active <= 1'b1;
    else if (last && in_mode)
      active <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_oe   <= 1'b0;
      sdat_oe   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      sclk_oe   <= shifting;
      sdat_oe   <= out_mode;
      cpu_rdata <= sr;
    end
  end

  ssu_rate_gen #(.CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst(rst), .run(run), .restart(access), .half(tmr_lo),
    .sclk(sclk_out), .rise_o(rise), .fall_o(fall)
  );

  ssu_bit_ctr #(.DW(DW)) u_bits (
    .clk(clk), .rst(rst), .clr(access), .step(rise && in_mode),
    .last(last), .flag(done_flag)
  );

  ssu_shreg #(.DW(DW)) u_sr (
    .clk(clk), .rst(rst), .load(cpu_wr), .wdata(cpu_wdata),
    .shift_in(rise && in_mode), .din(sdat_in),
    .rotate(fall && out_mode), .sr(sr)
  );

  assign sdat_out = sr[DW-1];

  // R1: off mode drops both enables next cycle
  a_r1_enables_off: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |=> (!sclk_oe && !sdat_oe));
  // R8: outside the shifting modes the clock is high next cycle
  a_r8_stop_high: assert property (@(posedge clk) disable iff (rst)
    (!shifting) |=> sclk_out);
  // R4: once done, the clock holds until an access
  a_r4_hold_after_done: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !access) |=> $stable(sclk_out));
  // R6: the flag is never raised in rotate-out mode
  a_r6_no_flag_out: assert property (@(posedge clk) disable iff (rst)
    (out_mode && !done_flag) |=> !done_flag);
endmodule

// File: tb/ser_shift_unit_tb.sv
module ser_shift_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'b000;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata, tmr_lo = 8'd2;
  logic       sdat_in = 1'b0;
  logic       sclk_out, sclk_oe, sdat_out, sdat_oe, done_flag;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ser_shift_unit u_dut (
    .clk(clk), .rst(rst), .mode(mode), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tmr_lo(tmr_lo),
    .sdat_in(sdat_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sdat_out(sdat_out), .sdat_oe(sdat_oe), .done_flag(done_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = v;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic wait_level(input logic lvl, output int n);
    n = 0;
    while (sclk_out !== lvl && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_rise();
    int n;
    wait_level(1'b0, n);
    wait_level(1'b1, n);
  endtask

  task automatic count_toggles(input int cycles, output int t);
    logic prev;
    t = 0; prev = sclk_out;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sclk_out !== prev) t++;
      prev = sclk_out;
    end
  endtask

  task automatic t_reset();
    check("R9 sclk_out", sclk_out, 1);
    check("R9 done_flag", done_flag, 0);
    check("R9 sclk_oe", sclk_oe, 0);
    check("R9 sdat_oe", sdat_oe, 0);
    check("R9 rdata", cpu_rdata, 0);
  endtask

  task automatic t_off();
    int t;
    mode = 3'b000;
    do_write(8'h5C);
    @(negedge clk);
    check("R1 rdata after write", cpu_rdata, 8'h5C);
    count_toggles(60, t);
    check("R1 no clock toggles", t, 0);
    check("R1 flag low", done_flag, 0);
    check("R1 sclk_oe low", sclk_oe, 0);
  endtask

  task automatic t_rate(input logic [7:0] n_val);
    int k;
    mode = 3'b001; tmr_lo = n_val;
    do_write(8'h00);
    wait_level(1'b0, k);
    check("R2 first fall delay", k, n_val + 2);
    wait_level(1'b1, k);
    check("R2 low phase", k, n_val + 2);
    wait_level(1'b0, k);
    check("R2 high phase", k, n_val + 2);
    check("R2 sclk_oe", sclk_oe, 1);
    for (int i = 0; i < 7; i++) wait_rise();
  endtask

  task automatic t_shift_in(input logic [7:0] p);
    int t, n;
    mode = 3'b001; tmr_lo = 8'd1;
    do_write(8'h00);
    for (int i = 0; i < 8; i++) begin
      wait_level(1'b0, n);
      sdat_in = p[7-i];
      wait_level(1'b1, n);
    end
    @(negedge clk); @(negedge clk);
    check("R4 flag after 8 rises", done_flag, 1);
    check("R3 received byte", cpu_rdata, p);
    count_toggles(40, t);
    check("R4 clock parked", t, 0);
    check("R4 clock high", sclk_out, 1);
  endtask

  task automatic t_clear_restart();
    int rises;
    do_write(8'h00);
    check("R5 flag cleared", done_flag, 0);
    check("R5 clock high after access", sclk_out, 1);
    for (int i = 0; i < 3; i++) wait_rise();
    do_write(8'h00);
    rises = 0;
    while (!done_flag && rises < 20) begin wait_rise(); rises++; end
    check("R5 eight rises after restart", rises, 8);
  endtask

  task automatic t_read_start();
    int k;
    mode = 3'b000;
    do_write(8'h3E);
    mode = 3'b001; tmr_lo = 8'd3; sdat_in = 1'b1;
    do_read();
    check("R7 read data", cpu_rdata, 8'h3E);
    wait_level(1'b0, k);
    check("R7 read starts shift", k, 5);
    for (int i = 0; i < 8; i++) wait_rise();
    @(negedge clk); @(negedge clk);
    check("R7 flag after read start", done_flag, 1);
    check("R7 ones shifted in", cpu_rdata, 8'hFF);
  endtask

  task automatic t_out(input logic [7:0] p);
    int t;
    mode = 3'b100; tmr_lo = 8'd1;
    do_write(p);
    check("R6 sdat_oe", sdat_oe, 1);
    check("R6 first bit", sdat_out, p[7]);
    for (int k = 1; k <= 8; k++) begin
      wait_rise();
      check($sformatf("R6 bit at rise %0d", k), sdat_out, p[(15-k)%8]);
    end
    @(negedge clk);
    check("R6 rotated back", cpu_rdata, p);
    check("R6 no flag", done_flag, 0);
    count_toggles(30, t);
    check("R6 keeps running", (t > 0) ? 1 : 0, 1);
  endtask

  task automatic t_stop();
    int t;
    mode = 3'b000;
    @(negedge clk); @(negedge clk);
    check("R8 clock high", sclk_out, 1);
    check("R8 sclk_oe off", sclk_oe, 0);
    check("R8 sdat_oe off", sdat_oe, 0);
    count_toggles(30, t);
    check("R8 no toggles", t, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_off();
    t_rate(8'd2);
    t_rate(8'd0);
    t_rate(8'd5);
    t_shift_in(8'hB4);
    t_clear_restart();
    t_read_start();
    t_out(8'hA6);
    t_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule